// File: doc/BRIEF.md
# Multi-channel interval down-timer

The block holds a set of independent down-counting channels behind a small word-addressed register port (address, write data, write strobe, combinational read data). Software gives each channel a 31-bit interval. A running channel counts down once per clock. When the interval runs out, the channel raises its flag and then either reloads and keeps going (repeat) or halts (one-shot). A new interval can take effect at once or can wait until the current interval ends. This lets software retime a periodic tick without breaking the period that is already in progress.

Two global registers help software pick and service channels. One reports the lowest-numbered channel that is not running, so software can claim a free timer. The other shows every channel's flag in a single word and clears any subset of them in one write. One interrupt output combines the flags of all channels that have their enable set.

Top module: `dntimer_top`

## Requirements
- R1: Channel n owns four word registers at byte address 16*n: +0x0 interval, +0x4 current count (read-only), +0x8 control, +0xC status. The idle register is at 0xF4 and the flag register at 0xF8. Every other address reads zero, including 0xF0, anything between the channel block and 0xF0, and any address with bits 1:0 nonzero. Writes to those addresses have no effect. Unused register bits read zero.
- R2: After synchronous active-low reset every register reads zero, the idle register reads 0x00 and the interrupt output is low.
- R3: Writing a nonzero interval V with bit 31 clear to a stopped channel starts it. The count reads V in the cycle after the write and then drops by one per clock. Status bit 1 (running) reads 1.
- R4: When a running channel's count is 1, the next clock sets its flag (status bit 0).
- R5: In repeat mode (control bits 2:1 = 0), the expiring clock reloads the held interval, so the flag is raised every V clocks and the channel keeps running.
- R6: In one-shot mode (control bits 2:1 = 1), the expiring clock stops the channel: the count reads 0 and the running bit reads 0. Mode codes 2 and 3 behave as repeat. Control bits 2:0 read back as written.
- R7: Writing an interval with bit 31 clear to a running channel does not disturb the count, and the new value is used at the next reload. If that held value is zero, the channel stops at expiry.
- R8: Writing an interval with bit 31 set loads bits 30:0 into the count on the next clock, whether the channel is running or not. A nonzero value runs and a zero value stops the channel with a count of 0. The interval register keeps bits 30:0 only.
- R9: Writing status with bit 0 = 1 clears the flag. Writing 0 to bit 0 leaves the flag alone. The running bit cannot be changed by writing status.
- R10: Bit n of the flag register (0xF8) reads channel n's flag. Writing 1 to bit n clears that flag, and writing 0 leaves it unchanged.
- R11: If a flag is set by expiry in the same clock as a status or flag-register clear, the flag ends up set.
- R12: The idle register's bits 7:4 hold the lowest-numbered channel that is not running, or 4 (reads 0x40) when every channel runs.
- R13: The interrupt output is high when any channel has both its flag and its control bit 0 (interrupt enable) set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 8 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one write per high clock |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The counting function is exercised with short and long intervals in repeat mode, in one-shot mode and with an unlisted mode code. Deferred interval writes are compared against immediate ones, so a design that swaps the two is caught. Zero intervals are written both deferred and immediate, which separates stop-at-expiry from stop-at-once. Flag clears are timed to land exactly on an expiry clock, through the status register and through the flag register, to show that set has priority. The idle register is swept as channels start one by one and then after a middle channel stops, which tells a lowest-index encoder from a highest-index one.

// File: rtl/dntimer_pkg.sv
// Package: shared constants and register-select encoding for the down-timer.
// Assumes 32-bit registers with word-aligned byte addressing.
package dntimer_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 31;              // interval / count width
    localparam int LOAD_BIT = CNT_W;         // immediate-load bit of interval write

    typedef enum logic [1:0] {
        SEL_IVAL = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    localparam logic [1:0] MODE_ONESHOT = 2'd1;
endpackage

// File: rtl/dntimer_chan.sv
// Module: one down-counting channel with held interval, mode, enable and flag.
// Assumes strobes are mutually exclusive decodes from the register port;
// the global clear may coincide with any of them.
module dntimer_chan
    import dntimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iv_we,
    input  logic              ctrl_we,
    input  logic              stat_we,
    input  logic              gclr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  ivl_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [2:0]        ctrl_o,
    output logic              run_o,
    output logic              flag_o
);
    logic [CNT_W-1:0] ivl_q, cnt_q;
    logic             run_q, flag_q, inten_q;
    logic [1:0]       mode_q;
    logic             expire, one_shot, wr_load, clr_req;

    assign expire   = run_q && (cnt_q == CNT_W'(1));
    assign one_shot = (mode_q == MODE_ONESHOT);
    assign wr_load  = iv_we && (wdata[LOAD_BIT] || !run_q);
    assign clr_req  = (stat_we && wdata[0]) || gclr;

    // Hold the most recently written interval for reloads.
    always_ff @(posedge clk) begin
        if (!rst_n)     ivl_q <= '0;
        else if (iv_we) ivl_q <= wdata[CNT_W-1:0];
    end

    // Count down, start, reload or stop the channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (wr_load) begin
            cnt_q <= wdata[CNT_W-1:0];
            run_q <= (wdata[CNT_W-1:0] != '0);
        end else if (expire) begin
            if (one_shot || ivl_q == '0) begin
                cnt_q <= '0;
                run_q <= 1'b0;
            end else begin
                cnt_q <= ivl_q;
            end
        end else if (run_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Interrupt flag: expiry sets, software clears, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (expire)  flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    // Control fields: interrupt enable and mode code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inten_q <= 1'b0;
            mode_q  <= 2'd0;
        end else if (ctrl_we) begin
            inten_q <= wdata[0];
            mode_q  <= wdata[2:1];
        end
    end

    assign ivl_o  = ivl_q;
    assign cnt_o  = cnt_q;
    assign ctrl_o = {mode_q, inten_q};
    assign run_o  = run_q;
    assign flag_o = flag_q;

    // R4: a count of 1 while running raises the flag on the next clock.
    p_flag_on_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q == CNT_W'(1)) |=> flag_q);

    // R3: an undisturbed running count drops by exactly one.
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != CNT_W'(1) && !iv_we) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R6: one-shot expiry stops the channel at a count of zero.
    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q == CNT_W'(1) && mode_q == MODE_ONESHOT && !iv_we)
        |=> (!run_q && cnt_q == '0));

    // R8: an immediate zero interval stops the channel on the next clock.
    p_immediate_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iv_we && wdata[LOAD_BIT] && wdata[CNT_W-1:0] == '0) |=> (!run_q && cnt_q == '0));

    // R3: a running channel never holds a zero count.
    p_run_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q != '0));
endmodule

// File: rtl/dntimer_idle.sv
// Module: finds the lowest-numbered channel that is not running.
// Assumes NCH fits the output width; returns NCH when all channels run.
module dntimer_idle #(
    parameter int NCH   = 4,
    parameter int IDX_W = $clog2(NCH + 1)
) (
    input  logic [NCH-1:0]   run_i,
    output logic [IDX_W-1:0] idx_o
);
    // Priority encode from the top down so the lowest index wins.
    always_comb begin
        idx_o = IDX_W'(NCH);
        for (int i = NCH - 1; i >= 0; i--) begin
            if (!run_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dntimer_top.sv
// Module: multi-channel interval down-timer with a word register port.
// Assumes NCH is a power of two of at most 8 so channels and globals fit
// below 0x100; reads are combinational and writes take effect on the clock.
module dntimer_top
    import dntimer_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int IDX_W   = $clog2(NCH + 1);
    localparam int CH_SPAN = NCH * 16;
    localparam logic [ADDR_W-1:0] OFF_IDLE  = ADDR_W'('hF4);
    localparam logic [ADDR_W-1:0] OFF_FLAGS = ADDR_W'('hF8);

    logic [CNT_W-1:0] ivl_a [NCH];
    logic [CNT_W-1:0] cnt_a [NCH];
    logic [2:0]       ctrl_a [NCH];
    logic [NCH-1:0]   run_v, flag_v, inten_v;
    logic [IDX_W-1:0] idle_idx;
    logic             in_ch, flags_we;
    logic [CH_W-1:0]  ch_idx;
    reg_sel_e         reg_sel;

    assign in_ch    = (int'(addr_i) < CH_SPAN) && (addr_i[1:0] == 2'b00);
    assign ch_idx   = addr_i[4 +: CH_W];
    assign reg_sel  = reg_sel_e'(addr_i[3:2]);
    assign flags_we = we_i && (addr_i == OFF_FLAGS);

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic hit;
        assign hit = we_i && in_ch && (ch_idx == CH_W'(n));
        dntimer_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .iv_we   (hit && reg_sel == SEL_IVAL),
            .ctrl_we (hit && reg_sel == SEL_CTRL),
            .stat_we (hit && reg_sel == SEL_STAT),
            .gclr    (flags_we && wdata_i[n]),
            .wdata   (wdata_i),
            .ivl_o   (ivl_a[n]),
            .cnt_o   (cnt_a[n]),
            .ctrl_o  (ctrl_a[n]),
            .run_o   (run_v[n]),
            .flag_o  (flag_v[n])
        );
        assign inten_v[n] = ctrl_a[n][0];
    end

    dntimer_idle #(.NCH(NCH), .IDX_W(IDX_W)) u_idle (
        .run_i (run_v),
        .idx_o (idle_idx)
    );

    // Select read data for the addressed register; unmapped reads zero.
    always_comb begin
        rdata_o = '0;
        if (in_ch) begin
            unique case (reg_sel)
                SEL_IVAL: rdata_o = {1'b0, ivl_a[ch_idx]};
                SEL_CNT:  rdata_o = {1'b0, cnt_a[ch_idx]};
                SEL_CTRL: rdata_o = {{(DATA_W-3){1'b0}}, ctrl_a[ch_idx]};
                SEL_STAT: rdata_o = {{(DATA_W-2){1'b0}}, run_v[ch_idx], flag_v[ch_idx]};
            endcase
        end else if (addr_i == OFF_IDLE) begin
            rdata_o = {{(DATA_W-IDX_W-4){1'b0}}, idle_idx, 4'b0000};
        end else if (addr_i == OFF_FLAGS) begin
            rdata_o = {{(DATA_W-NCH){1'b0}}, flag_v};
        end
    end

    assign irq_o = |(flag_v & inten_v);

    // R12: a reported idle channel is indeed not running.
    p_idle_is_stopped_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idle_idx) < NCH) |-> !run_v[idle_idx[CH_W-1:0]]);

    // R12: with every channel running the encoder reports NCH.
    p_idle_all_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (&run_v) |-> (int'(idle_idx) == NCH));

    // R2: the interrupt stays low in the first cycle after reset.
    p_irq_quiet_after_reset_r2: assert property (@(posedge clk)
        !rst_n |=> !irq_o);
endmodule

// File: tb/dntimer_top_tb.sv
// Bench: directed scenarios for the down-timer, one task per scenario.
module dntimer_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic        we_i = 1'b0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dntimer_top dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
        .we_i(we_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] a_iv(int n); return 8'(n*16);      endfunction
    function automatic logic [7:0] a_tm(int n); return 8'(n*16 + 4);  endfunction
    function automatic logic [7:0] a_ct(int n); return 8'(n*16 + 8);  endfunction
    function automatic logic [7:0] a_st(int n); return 8'(n*16 + 12); endfunction
    localparam logic [7:0] A_IDLE = 8'hF4;
    localparam logic [7:0] A_FLG  = 8'hF8;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // One write: drive now (just after a falling edge), one rising edge passes.
    task automatic wr(logic [7:0] a, logic [31:0] d);
        addr_i = a; wdata_i = d; we_i = 1'b1;
        @(negedge clk);
        we_i = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
        addr_i = a;
        #1;
        chk(tag, rdata_o, exp);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R2 idle after reset", A_IDLE, 32'h0);
        rd_chk("R2 count after reset", a_tm(0), 32'h0);
        rd_chk("R2 status after reset", a_st(2), 32'h0);
        chk("R2 irq after reset", {31'b0, irq_o}, 32'h0);
        wr(8'hF0, 32'hFFFF_FFFF);
        rd_chk("R1 0xF0 reads zero", 8'hF0, 32'h0);
        wr(8'h01, 32'h0000_0005);
        rd_chk("R1 misaligned write ignored", a_st(0), 32'h0);
        rd_chk("R1 gap address reads zero", 8'h40, 32'h0);
    endtask

    task automatic t_start_repeat();
        wr(a_iv(0), 32'd10);
        rd_chk("R3 count loads V", a_tm(0), 32'd10);
        tick(3);
        rd_chk("R3 count after 3 clocks", a_tm(0), 32'd7);
        rd_chk("R3 running bit", a_st(0), 32'h2);
        tick(6);
        rd_chk("R4 no flag at count 1", a_st(0), 32'h2);
        tick(1);
        rd_chk("R4 flag after expiry", a_st(0), 32'h3);
        rd_chk("R5 reload to V", a_tm(0), 32'd10);
        chk("R13 irq low while disabled", {31'b0, irq_o}, 32'h0);
        wr(a_st(0), 32'h1);
        rd_chk("R9 status clear", a_st(0), 32'h2);
        tick(9);
        rd_chk("R5 flag again after V clocks", a_st(0), 32'h3);
        wr(a_iv(0), 32'h8000_0000);
        rd_chk("R8 immediate zero stops", a_st(0), 32'h1);
        rd_chk("R8 stopped count zero", a_tm(0), 32'h0);
        rd_chk("R10 flag register view", A_FLG, 32'h1);
        wr(A_FLG, 32'h1);
        rd_chk("R10 global clear", a_st(0), 32'h0);
    endtask

    task automatic t_oneshot();
        wr(a_ct(1), 32'h3);
        rd_chk("R6 control readback", a_ct(1), 32'h3);
        wr(a_iv(1), 32'd5);
        tick(4);
        chk("R13 irq low before expiry", {31'b0, irq_o}, 32'h0);
        tick(1);
        rd_chk("R6 one-shot stopped", a_st(1), 32'h1);
        rd_chk("R6 one-shot count zero", a_tm(1), 32'h0);
        chk("R13 irq high", {31'b0, irq_o}, 32'h1);
        tick(3);
        rd_chk("R6 stays stopped", a_tm(1), 32'h0);
        rd_chk("R10 flag bit 1", A_FLG, 32'h2);
        wr(A_FLG, 32'h1);
        rd_chk("R10 zero bit leaves flag", A_FLG, 32'h2);
        wr(A_FLG, 32'h2);
        rd_chk("R10 bit 1 cleared", A_FLG, 32'h0);
        chk("R13 irq low after clear", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_deferred();
        wr(a_iv(2), 32'd8);
        tick(2);
        wr(a_iv(2), 32'd3);
        rd_chk("R7 count undisturbed", a_tm(2), 32'd5);
        rd_chk("R7 interval held", a_iv(2), 32'd3);
        tick(5);
        rd_chk("R7 new value at reload", a_tm(2), 32'd3);
        rd_chk("R7 flag at old expiry", a_st(2), 32'h3);
        tick(3);
        rd_chk("R7 new period", a_tm(2), 32'd3);
        wr(a_iv(2), 32'd0);
        tick(2);
        rd_chk("R7 zero held stops at expiry", a_st(2), 32'h1);
        rd_chk("R7 zero held count", a_tm(2), 32'h0);
        wr(a_st(2), 32'h1);
    endtask

    task automatic t_immediate();
        wr(a_iv(3), 32'd20);
        tick(2);
        wr(a_iv(3), 32'h8000_0004);
        rd_chk("R8 immediate reload", a_tm(3), 32'd4);
        rd_chk("R8 interval keeps 31 bits", a_iv(3), 32'd4);
        rd_chk("R8 still running", a_st(3), 32'h2);
        wr(a_iv(3), 32'h8000_0000);
    endtask

    task automatic t_idle();
        rd_chk("R12 all idle", A_IDLE, 32'h00);
        wr(a_iv(0), 32'd100);
        rd_chk("R12 ch1 lowest idle", A_IDLE, 32'h10);
        wr(a_iv(1), 32'd100);
        rd_chk("R12 ch2 lowest idle", A_IDLE, 32'h20);
        wr(a_iv(2), 32'd100);
        rd_chk("R12 ch3 lowest idle", A_IDLE, 32'h30);
        wr(a_iv(3), 32'd100);
        rd_chk("R12 none idle", A_IDLE, 32'h40);
        wr(a_iv(1), 32'h8000_0000);
        rd_chk("R12 middle channel idle", A_IDLE, 32'h10);
        wr(a_iv(0), 32'h8000_0000);
        wr(a_iv(2), 32'h8000_0000);
        wr(a_iv(3), 32'h8000_0000);
        rd_chk("R12 all idle again", A_IDLE, 32'h00);
    endtask

    task automatic t_set_wins();
        wr(a_iv(0), 32'd3);
        tick(2);
        wr(a_st(0), 32'h1);
        rd_chk("R11 status clear loses to set", a_st(0), 32'h3);
        wr(a_st(0), 32'h1);
        rd_chk("R9 clear off expiry", a_st(0), 32'h2);
        tick(1);
        wr(A_FLG, 32'h1);
        rd_chk("R11 global clear loses to set", a_st(0), 32'h3);
        wr(a_st(0), 32'h2);
        rd_chk("R9 writing 0 keeps flag and run", a_st(0), 32'h3);
        wr(a_iv(0), 32'h8000_0000);
        wr(a_st(0), 32'h2);
        rd_chk("R9 running bit not writable", a_st(0), 32'h1);
        wr(a_st(0), 32'h1);
    endtask

    task automatic t_mode_code2();
        wr(a_ct(1), 32'h4);
        rd_chk("R6 control code 2 readback", a_ct(1), 32'h4);
        wr(a_iv(1), 32'd2);
        tick(2);
        rd_chk("R6 code 2 repeats", a_st(1), 32'h3);
        rd_chk("R6 code 2 reload", a_tm(1), 32'd2);
        wr(a_iv(1), 32'h8000_0000);
        wr(a_st(1), 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_start_repeat();
        t_oneshot();
        t_deferred();
        t_immediate();
        t_idle();
        t_set_wins();
        t_mode_code2();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule